// File: doc/BRIEF.md
# Dual-Bus Register Datapath

This block holds the working registers of a small 16-bit processor and connects them through two internal buses. One bus carries data words and the other carries memory addresses. There are eight registers: four general registers, an accumulator, a program counter, a stack pointer and an operand register. A register can drive either bus. Every register loads from the data bus, and the accumulator can take the ALU result in its place. The external data input is one more data-bus source, which lets an operand or a memory word be captured from outside.

The controlling sequencer issues one-hot drive requests per bus, load enables per register and two output enables. The two buses appear on the external data and address outputs through output-enable gating. A gated-off output reads as zero, so it can be merged onto a shared line by an outer buffer. Because any general register can drive the address bus, each one can serve as a memory pointer. The operand register drives the data bus for immediate operands and the address bus for direct addresses.

Top module: `dual_bus_datapath`

## Requirements
- R1: An active-low `rst_n` clears all eight registers to zero at once, without waiting for a clock edge, and they stay zero while it is held low.
- R2: On a rising clock edge, each register whose `load_en` bit is set takes the data-bus value. Each register whose bit is clear keeps its value. Bit order for `load_en` and `abus_req`: 0 B, 1 C, 2 D, 3 E, 4 accumulator, 5 program counter, 6 stack pointer, 7 operand register.
- R3: When `dbus_req` bit k is set, register k's value is on the data bus in the same cycle. `dbus_req` bits 0 to 7 use the R2 order, and bit 8 selects `ext_din`.
- R4: When `abus_req` bit k is set, register k's value is on the address bus in the same cycle, for every register except the accumulator.
- R5: The accumulator never reaches the address bus. If only `abus_req` bit 4 is set, the address bus reads zero.
- R6: When `acc_sel_alu` is 1, an accumulator load takes `alu_res` instead of the data bus. Other registers loading in the same cycle still take the data bus.
- R7: A bus with no drive request reads as zero.
- R8: Each bus carries only its own requested source, and at most one source may be requested per bus per cycle. A data-bus request leaves the address bus at zero.
- R9: `ext_dout` shows the data bus only while `data_oe` is 1, and `ext_addr` shows the address bus only while `addr_oe` is 1. Otherwise each reads zero.
- R10: The operand register captures a word from `ext_din` and can then drive the data bus, for an immediate operand, or the address bus, for a direct address.
- R11: One register may drive both buses in the same cycle, and a register-to-register copy over the data bus completes in a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbus_req | input | 9 | One-hot data-bus drive request (bit 8 = external data in) |
| abus_req | input | 8 | One-hot address-bus drive request |
| load_en | input | 8 | Per-register load enable |
| acc_sel_alu | input | 1 | Accumulator loads the ALU result instead of the data bus |
| alu_res | input | 16 | ALU result word |
| ext_din | input | 16 | External data input |
| data_oe | input | 1 | Output enable for the external data lines |
| addr_oe | input | 1 | Output enable for the external address lines |
| ext_dout | output | 16 | External data lines (zero when disabled) |
| ext_addr | output | 16 | External address lines (zero when disabled) |

## Verification
Both bus paths and the output gating are combinational. A drive request or an output enable therefore shows on `ext_dout` or `ext_addr` in the cycle it is applied. The bench changes inputs just after a falling edge and samples one nanosecond later, well before the next rising edge. A load is visible one rising edge later, so register contents are read back through the data bus in the cycle after the load. Reset acts at once, and the bench checks it without clocking.

// File: rtl/dbdp_pkg.sv
package dbdp_pkg;
  localparam int NUM_REGS = 8;
  localparam int NUM_DSRC = NUM_REGS + 1;
  localparam int IDX_B    = 0;
  localparam int IDX_C    = 1;
  localparam int IDX_D    = 2;
  localparam int IDX_E    = 3;
  localparam int IDX_ACC  = 4;
  localparam int IDX_PC   = 5;
  localparam int IDX_SP   = 6;
  localparam int IDX_OPR  = 7;
  localparam int IDX_EXT  = NUM_REGS;
endpackage

// File: rtl/dbdp_bus_arb.sv
module dbdp_bus_arb #(
  parameter int N_SRC = 8,
  parameter int W     = 16
) (
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC-1:0][W-1:0] src,
  output logic [W-1:0]            bus
);
  // Fixed priority: the lowest requested index owns the bus.
  always_comb begin
    logic taken;
    taken = 1'b0;
    bus   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && !taken) begin
        bus   = src[i];
        taken = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbdp_regfile.sv
module dbdp_regfile #(
  parameter int N_REG   = 8,
  parameter int W       = 16,
  parameter int ACC_IDX = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REG-1:0]        load_en,
  input  logic                    acc_sel_alu,
  input  logic [W-1:0]            dbus,
  input  logic [W-1:0]            alu_res,
  output logic [N_REG-1:0][W-1:0] q
);
  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    logic [W-1:0] d_src;
    logic [W-1:0] d_next;

    if (g == ACC_IDX) begin : g_acc
      always_comb d_src = acc_sel_alu ? alu_res : dbus;
    end else begin : g_plain
      always_comb d_src = dbus;
    end

    always_comb begin
      d_next = q[g];
      if (load_en[g]) d_next = d_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= '0;
      else        q[g] <= d_next;
    end
  end
endmodule

// File: rtl/dbdp_out_gate.sv
module dbdp_out_gate #(
  parameter int W = 16
) (
  input  logic         oe,
  input  logic [W-1:0] bus,
  output logic [W-1:0] pin
);
  always_comb pin = oe ? bus : '0;
endmodule

// File: rtl/dual_bus_datapath.sv
module dual_bus_datapath
  import dbdp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DSRC-1:0] dbus_req,
  input  logic [NUM_REGS-1:0] abus_req,
  input  logic [NUM_REGS-1:0] load_en,
  input  logic                acc_sel_alu,
  input  logic [DATA_W-1:0]   alu_res,
  input  logic [DATA_W-1:0]   ext_din,
  input  logic                data_oe,
  input  logic                addr_oe,
  output logic [DATA_W-1:0]   ext_dout,
  output logic [DATA_W-1:0]   ext_addr
);
  localparam logic [NUM_REGS-1:0] ADDR_MASK = ~(NUM_REGS'(1) << IDX_ACC);

  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [NUM_DSRC-1:0][DATA_W-1:0] dsrc;
  logic [NUM_REGS-1:0]             abus_req_ok;
  logic [DATA_W-1:0]               dbus;
  logic [DATA_W-1:0]               abus;

  always_comb dsrc        = {ext_din, reg_q};
  always_comb abus_req_ok = abus_req & ADDR_MASK;

  dbdp_regfile #(.N_REG(NUM_REGS), .W(DATA_W), .ACC_IDX(IDX_ACC)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .acc_sel_alu(acc_sel_alu),
    .dbus(dbus), .alu_res(alu_res), .q(reg_q)
  );

  dbdp_bus_arb #(.N_SRC(NUM_DSRC), .W(DATA_W)) u_darb (
    .req(dbus_req), .src(dsrc), .bus(dbus)
  );

  dbdp_bus_arb #(.N_SRC(NUM_REGS), .W(DATA_W)) u_aarb (
    .req(abus_req_ok), .src(reg_q), .bus(abus)
  );

  dbdp_out_gate #(.W(DATA_W)) u_dgate (.oe(data_oe), .bus(dbus), .pin(ext_dout));
  dbdp_out_gate #(.W(DATA_W)) u_agate (.oe(addr_oe), .bus(abus), .pin(ext_addr));
endmodule

// File: rtl/dbdp_checker.sv
module dbdp_checker
  import dbdp_pkg::*;
#(
  parameter int W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_DSRC-1:0]      dbus_req,
  input logic [NUM_REGS-1:0]      abus_req,
  input logic [NUM_REGS-1:0]      load_en,
  input logic                     acc_sel_alu,
  input logic [W-1:0]             alu_res,
  input logic                     data_oe,
  input logic                     addr_oe,
  input logic [W-1:0]             ext_dout,
  input logic [W-1:0]             ext_addr,
  input logic [W-1:0]             dbus,
  input logic [W-1:0]             abus,
  input logic [NUM_REGS-1:0][W-1:0] reg_q
);
  AST_DBUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dbus_req) <= 1); // R8
  AST_ABUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(abus_req) <= 1); // R8
  AST_ACC_OFF_ABUS: assert property (@(posedge clk) disable iff (!rst_n)
    (abus_req == (NUM_REGS'(1) << IDX_ACC)) |-> (abus == '0)); // R5
  AST_B_LOADS_DBUS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en[IDX_B] |=> (reg_q[IDX_B] == $past(dbus))); // R2
  AST_SP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en[IDX_SP] |=> $stable(reg_q[IDX_SP])); // R2
  AST_ACC_TAKES_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en[IDX_ACC] && acc_sel_alu) |=> (reg_q[IDX_ACC] == $past(alu_res))); // R6
  AST_IDLE_DBUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_req == '0) |-> (dbus == '0)); // R7
  AST_DOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (ext_dout == '0)); // R9
  AST_ADDR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |-> (ext_addr == '0)); // R9
endmodule

bind dual_bus_datapath dbdp_checker #(.W(DATA_W)) u_dbdp_chk (
  .clk(clk), .rst_n(rst_n), .dbus_req(dbus_req), .abus_req(abus_req),
  .load_en(load_en), .acc_sel_alu(acc_sel_alu), .alu_res(alu_res),
  .data_oe(data_oe), .addr_oe(addr_oe), .ext_dout(ext_dout),
  .ext_addr(ext_addr), .dbus(dbus), .abus(abus), .reg_q(reg_q)
);

// File: tb/dual_bus_datapath_bench.sv
module dual_bus_datapath_bench;
  localparam int W = 16;
  localparam int NR = 8;
  localparam int I_ACC = 4;
  localparam int I_OPR = 7;
  localparam int I_EXT = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR:0]   dbus_req = '0;
  logic [NR-1:0] abus_req = '0;
  logic [NR-1:0] load_en = '0;
  logic          acc_sel_alu = 1'b0;
  logic [W-1:0]  alu_res = '0;
  logic [W-1:0]  ext_din = '0;
  logic          data_oe = 1'b0;
  logic          addr_oe = 1'b0;
  logic [W-1:0]  ext_dout;
  logic [W-1:0]  ext_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] model [NR];

  always #2 clk = ~clk;

  dual_bus_datapath u_dual_bus_datapath (
    .clk(clk), .rst_n(rst_n), .dbus_req(dbus_req), .abus_req(abus_req),
    .load_en(load_en), .acc_sel_alu(acc_sel_alu), .alu_res(alu_res),
    .ext_din(ext_din), .data_oe(data_oe), .addr_oe(addr_oe),
    .ext_dout(ext_dout), .ext_addr(ext_addr)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    dbus_req = '0; abus_req = '0; load_en = '0; acc_sel_alu = 1'b0;
    data_oe = 1'b0; addr_oe = 1'b0;
  endtask

  task automatic read_d(input int k, output logic [W-1:0] v);
    @(negedge clk);
    idle();
    dbus_req = (NR+1)'(1) << k; data_oe = 1'b1;
    #1 v = ext_dout;
    idle();
  endtask

  task automatic write_ext(input int k, input logic [W-1:0] v);
    @(negedge clk);
    idle();
    dbus_req = (NR+1)'(1) << I_EXT; ext_din = v; load_en = NR'(1) << k;
    @(negedge clk);
    idle();
    model[k] = v;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NR; k++) begin
      read_d(k, v);
      chk($sformatf("R1 reg%0d after reset", k), v, '0);
      model[k] = '0;
    end
  endtask

  task automatic t_load_all();
    logic [W-1:0] v;
    for (int k = 0; k < NR; k++) write_ext(k, W'(16'hA500 + 16'h0101 * k));
    for (int k = 0; k < NR; k++) begin
      read_d(k, v);
      chk($sformatf("R2 R3 reg%0d load", k), v, model[k]);
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] v;
    @(negedge clk);
    idle();
    dbus_req = (NR+1)'(1) << I_EXT; ext_din = 16'hDEAD;
    repeat (2) @(negedge clk);
    idle();
    for (int k = 0; k < NR; k++) begin
      read_d(k, v);
      chk($sformatf("R2 reg%0d holds", k), v, model[k]);
    end
  endtask

  task automatic t_addr();
    for (int k = 0; k < NR; k++) begin
      if (k == I_ACC) continue;
      @(negedge clk);
      idle();
      abus_req = NR'(1) << k; addr_oe = 1'b1;
      #1 chk($sformatf("R4 reg%0d on address bus", k), ext_addr, model[k]);
      idle();
    end
  endtask

  task automatic t_acc_barred();
    @(negedge clk);
    idle();
    abus_req = NR'(1) << I_ACC; addr_oe = 1'b1;
    #1 chk("R5 accumulator kept off address bus", ext_addr, '0);
    idle();
  endtask

  task automatic t_alu();
    logic [W-1:0] v;
    @(negedge clk);
    idle();
    acc_sel_alu = 1'b1; alu_res = 16'hBEEF;
    dbus_req = (NR+1)'(1) << I_EXT; ext_din = 16'h1234;
    load_en = (NR'(1) << I_ACC) | NR'(1);
    @(negedge clk);
    idle();
    model[I_ACC] = 16'hBEEF; model[0] = 16'h1234;
    read_d(I_ACC, v);
    chk("R6 accumulator took ALU result", v, 16'hBEEF);
    read_d(0, v);
    chk("R6 B took data bus alongside", v, 16'h1234);
  endtask

  task automatic t_idle_zero();
    @(negedge clk);
    idle();
    data_oe = 1'b1; addr_oe = 1'b1;
    #1;
    chk("R7 idle data bus", ext_dout, '0);
    chk("R7 idle address bus", ext_addr, '0);
    idle();
  endtask

  task automatic t_separation();
    @(negedge clk);
    idle();
    dbus_req = (NR+1)'(1) << 2; data_oe = 1'b1; addr_oe = 1'b1;
    #1;
    chk("R8 data request leaves address bus", ext_addr, '0);
    chk("R8 data bus carries D", ext_dout, model[2]);
    idle();
  endtask

  task automatic t_oe();
    @(negedge clk);
    idle();
    dbus_req = (NR+1)'(1) << 1; abus_req = NR'(1) << 1;
    #1;
    chk("R9 data lines gated", ext_dout, '0);
    chk("R9 address lines gated", ext_addr, '0);
    idle();
  endtask

  task automatic t_operand();
    logic [W-1:0] v;
    write_ext(I_OPR, 16'h4C21);
    @(negedge clk);
    idle();
    abus_req = NR'(1) << I_OPR; addr_oe = 1'b1;
    #1 chk("R10 operand direct address", ext_addr, 16'h4C21);
    idle();
    @(negedge clk);
    dbus_req = (NR+1)'(1) << I_OPR; load_en = NR'(1) << I_ACC;
    @(negedge clk);
    idle();
    model[I_ACC] = 16'h4C21;
    read_d(I_ACC, v);
    chk("R10 operand immediate into accumulator", v, 16'h4C21);
  endtask

  task automatic t_both_and_copy();
    logic [W-1:0] v;
    @(negedge clk);
    idle();
    dbus_req = (NR+1)'(1) << 1; abus_req = NR'(1) << 1;
    data_oe = 1'b1; addr_oe = 1'b1;
    #1;
    chk("R11 C on data bus", ext_dout, model[1]);
    chk("R11 C on address bus", ext_addr, model[1]);
    idle();
    @(negedge clk);
    dbus_req = (NR+1)'(1) << 2; load_en = NR'(1) << 3;
    @(negedge clk);
    idle();
    model[3] = model[2];
    read_d(3, v);
    chk("R11 copy D to E", v, model[2]);
  endtask

  task automatic t_async_reset();
    logic [W-1:0] v;
    @(negedge clk);
    idle();
    #1 rst_n = 1'b0;
    dbus_req = (NR+1)'(1) << 5; data_oe = 1'b1;
    #0.5 v = ext_dout;
    chk("R1 immediate clear of PC", v, '0);
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NR; k++) model[k] = '0;
    read_d(I_ACC, v);
    chk("R1 accumulator cleared", v, '0);
  endtask

  initial begin
    t_reset();
    t_load_all();
    t_hold();
    t_addr();
    t_acc_barred();
    t_alu();
    t_idle_zero();
    t_separation();
    t_oe();
    t_operand();
    t_both_and_copy();
    t_async_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule